// File: doc/BRIEF.md
# Reordered Gram-Schmidt QR Sequencer

This block is the control sequencer of a QR decomposition engine that runs modified Gram-Schmidt on a matrix with `N_COLS` columns. It does no arithmetic. It produces an ordered stream of instructions for two shared datapath resources. One is a multiply-add unit with many lanes that performs dot products and column updates over vectors. The other is a single unit that performs divides and square roots. Each instruction is an opcode plus two column indices. Instructions enter an instruction FIFO, and the datapath takes them from there as its operands become ready.

The schedule has two passes. The first pass uses only squared norms and raw dot products. For each column it computes the squared norm, then the cross dot products with every later column, then the update of every later column. In that update, the later column loses its projection onto the current column, scaled by the raw dot product over the squared norm. No square root occurs in this pass. The second pass handles one column at a time. For each column it takes the square root of the squared norm, divides every raw dot product of that column by the result, and finally scales the column itself to form the orthonormal vector. This keeps square roots and normalising divides off the critical dependency chain of the first pass.

A one-cycle `start` launches a run. The instruction port is a valid/ready pair. A FIFO almost-full input holds back issue. A one-cycle `done` reports that the last instruction has been accepted.

Top module: `qr_sched_seq`

## Requirements
- R1: After reset, `instr_valid` and `done` are low, and they stay low until `start` is seen.
- R2: For each column k, taken in ascending order, the first-pass group opens with a self dot product: `instr_op` = 3'd1 with `instr_k` = `instr_j` = k.
- R3: After the self dot product of column k come the cross dot products `instr_op` = 3'd1 with `instr_k` = k, for j = k+1 up to N_COLS-1 in ascending order. In every instruction, `instr_j` >= `instr_k`.
- R4: After the cross dot products of column k come the column updates `instr_op` = 3'd2 with `instr_k` = k, for j = k+1 up to N_COLS-1 in ascending order.
- R5: No square root or divide (`instr_op` 3'd3, 3'd4 or 3'd5) is issued until every first-pass instruction of every column has been accepted. No dot product or update is issued after the first square root.
- R6: In the second pass, for each column k in ascending order, the sequencer issues a square root (`instr_op` = 3'd3, j = k). It then issues divides of the raw values (`instr_op` = 3'd4) for j = k+1 up to N_COLS-1 in ascending order, and then a column scale (`instr_op` = 3'd5, j = k).
- R7: While `fifo_afull` is high, `instr_valid` is low. Back-pressure neither drops nor repeats any instruction.
- R8: While `instr_valid` is high and `instr_ready` is low, `instr_op`, `instr_k` and `instr_j` keep their values into the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the clock edge that accepts the final column-scale instruction, and at no other time.
- R10: A `start` during a run is ignored. The run continues without a restart, and nothing is issued after `done` until a new `start` arrives.
- R11: A run accepts exactly 3·N_COLS + 3·N_COLS·(N_COLS-1)/2 instructions (30 for N_COLS = 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a decomposition schedule |
| fifo_afull | input | 1 | Instruction FIFO almost full; holds back issue |
| instr_ready | input | 1 | FIFO accepts the presented instruction |
| instr_valid | output | 1 | Instruction presented |
| instr_op | output | 3 | Opcode: 1 dot, 2 update, 3 sqrt, 4 divide raw value, 5 scale column |
| instr_k | output | IDX_W | Pivot column index |
| instr_j | output | IDX_W | Second column index (equal to k for diagonal work) |
| done | output | 1 | One-cycle pulse after the final instruction is accepted |

## Verification
The bench builds the full expected instruction list from nested loops and compares every accepted instruction against it. This exposes a swapped pass order, a missing cross term, or an off-by-one j limit as a wrong opcode or index at a known position. Random `instr_ready` and `fifo_afull` patterns target back-pressure. A design that advances on a stalled cycle would skip an entry, and one that re-presents after acceptance would repeat an entry. Both show up as a mismatch or a wrong total. Mid-run `start` pulses check that a busy sequencer does not restart from column 0. The `done` timing check catches a pulse that arrives early, arrives late, or lasts more than one cycle.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_DOT  = 3'd1,
      OP_UPD  = 3'd2,
      OP_SQRT = 3'd3,
      OP_DIVR = 3'd4,
      OP_DIVQ = 3'd5
   } qrs_op_e;

   typedef enum logic [2:0] {
      ST_NORM,
      ST_XDOT,
      ST_UPD,
      ST_SQRT,
      ST_DIVR,
      ST_DIVQ
   } qrs_stage_e;

   function automatic qrs_op_e stage_to_op(input qrs_stage_e st);
      case (st)
         ST_NORM, ST_XDOT: return OP_DOT;
         ST_UPD:           return OP_UPD;
         ST_SQRT:          return OP_SQRT;
         ST_DIVR:          return OP_DIVR;
         ST_DIVQ:          return OP_DIVQ;
         default:          return OP_NOP;
      endcase
   endfunction

endpackage

// File: rtl/qrs_issue_ctl.sv
module qrs_issue_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fire,
   input  logic last,
   output logic launch,
   output logic busy,
   output logic done
);

   assign launch = start & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= fire & last;
         if (launch)
            busy <= 1'b1;
         else if (fire && last)
            busy <= 1'b0;
      end
   end

endmodule

// File: rtl/qrs_walker.sv
module qrs_walker
   import qrs_pkg::*;
#(
   parameter int N_COLS = 4,
   parameter int IDX_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             fire,
   output qrs_stage_e       stage,
   output logic [IDX_W-1:0] k_idx,
   output logic [IDX_W-1:0] j_idx,
   output logic             last
);

   localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(N_COLS - 1);
   localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

   logic k_end;
   logic j_end;

   generate
      if (N_COLS == 1) begin : g_single
         assign k_end = 1'b1;
         assign j_end = 1'b1;
      end else begin : g_multi
         assign k_end = (k_idx == IDX_MAX);
         assign j_end = (j_idx == IDX_MAX);
      end
   endgenerate

   qrs_stage_e       nxt_stage;
   logic [IDX_W-1:0] nxt_k;
   logic [IDX_W-1:0] nxt_j;

   always_comb begin
      nxt_stage = stage;
      nxt_k     = k_idx;
      nxt_j     = j_idx;
      case (stage)
         ST_NORM: begin
            if (k_end) begin
               nxt_stage = ST_SQRT;
               nxt_k     = '0;
               nxt_j     = '0;
            end else begin
               nxt_stage = ST_XDOT;
               nxt_j     = k_idx + IDX_ONE;
            end
         end
         ST_XDOT: begin
            if (j_end) begin
               nxt_stage = ST_UPD;
               nxt_j     = k_idx + IDX_ONE;
            end else begin
               nxt_j = j_idx + IDX_ONE;
            end
         end
         ST_UPD: begin
            if (j_end) begin
               nxt_stage = ST_NORM;
               nxt_k     = k_idx + IDX_ONE;
               nxt_j     = k_idx + IDX_ONE;
            end else begin
               nxt_j = j_idx + IDX_ONE;
            end
         end
         ST_SQRT: begin
            if (k_end) begin
               nxt_stage = ST_DIVQ;
               nxt_j     = k_idx;
            end else begin
               nxt_stage = ST_DIVR;
               nxt_j     = k_idx + IDX_ONE;
            end
         end
         ST_DIVR: begin
            if (j_end) begin
               nxt_stage = ST_DIVQ;
               nxt_j     = k_idx;
            end else begin
               nxt_j = j_idx + IDX_ONE;
            end
         end
         ST_DIVQ: begin
            nxt_stage = ST_SQRT;
            nxt_k     = k_idx + IDX_ONE;
            nxt_j     = k_idx + IDX_ONE;
         end
         default: begin
            nxt_stage = ST_NORM;
            nxt_k     = '0;
            nxt_j     = '0;
         end
      endcase
   end

   assign last = (stage == ST_DIVQ) && k_end;

   always_ff @(posedge clk) begin
      if (!rst_n || launch) begin
         stage <= ST_NORM;
         k_idx <= '0;
         j_idx <= '0;
      end else if (fire) begin
         stage <= nxt_stage;
         k_idx <= nxt_k;
         j_idx <= nxt_j;
      end
   end

endmodule

// File: rtl/qrs_instr_fmt.sv
module qrs_instr_fmt
   import qrs_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  qrs_stage_e       stage,
   input  logic [IDX_W-1:0] k_idx,
   input  logic [IDX_W-1:0] j_idx,
   output logic [2:0]       op,
   output logic [IDX_W-1:0] out_k,
   output logic [IDX_W-1:0] out_j
);

   qrs_op_e op_e;

   assign op_e  = stage_to_op(stage);
   assign op    = op_e;
   assign out_k = k_idx;
   assign out_j = j_idx;

endmodule

// File: rtl/qr_sched_seq.sv
module qr_sched_seq
   import qrs_pkg::*;
#(
   parameter int N_COLS = 4,
   parameter int IDX_W  = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             fifo_afull,
   input  logic             instr_ready,
   output logic             instr_valid,
   output logic [2:0]       instr_op,
   output logic [IDX_W-1:0] instr_k,
   output logic [IDX_W-1:0] instr_j,
   output logic             done
);

   generate
      if (N_COLS < 1) begin : g_bad_cols
         $error("qr_sched_seq: N_COLS must be at least 1");
      end
      if ((1 << IDX_W) < N_COLS) begin : g_bad_idx
         $error("qr_sched_seq: IDX_W too narrow for N_COLS");
      end
   endgenerate

   logic             launch;
   logic             busy;
   logic             fire;
   logic             last;
   qrs_stage_e       stage;
   logic [IDX_W-1:0] k_idx;
   logic [IDX_W-1:0] j_idx;

   assign instr_valid = busy & ~fifo_afull;
   assign fire        = instr_valid & instr_ready;

   qrs_issue_ctl u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .fire   (fire),
      .last   (last),
      .launch (launch),
      .busy   (busy),
      .done   (done)
   );

   qrs_walker #(
      .N_COLS (N_COLS),
      .IDX_W  (IDX_W)
   ) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .fire   (fire),
      .stage  (stage),
      .k_idx  (k_idx),
      .j_idx  (j_idx),
      .last   (last)
   );

   qrs_instr_fmt #(
      .IDX_W (IDX_W)
   ) u_fmt (
      .stage (stage),
      .k_idx (k_idx),
      .j_idx (j_idx),
      .op    (instr_op),
      .out_k (instr_k),
      .out_j (instr_j)
   );

endmodule

// File: rtl/qrs_seq_checker.sv
module qrs_seq_checker
   import qrs_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_afull,
   input logic             instr_ready,
   input logic             instr_valid,
   input logic [2:0]       instr_op,
   input logic [IDX_W-1:0] instr_k,
   input logic [IDX_W-1:0] instr_j,
   input logic             done
);

   logic in_p2;

   always_ff @(posedge clk) begin
      if (!rst_n)
         in_p2 <= 1'b0;
      else if (done)
         in_p2 <= 1'b0;
      else if (instr_valid && instr_ready && instr_op == OP_SQRT)
         in_p2 <= 1'b1;
   end

   p_stall_afull_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_afull |-> !instr_valid);

   p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !instr_ready) |=>
         ($stable(instr_op) && $stable(instr_k) && $stable(instr_j)));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_scale_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(instr_valid && instr_ready && instr_op == OP_DIVQ));

   p_j_not_below_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |-> (instr_j >= instr_k));

   p_pass_one_ops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !in_p2) |->
         (instr_op == OP_DOT || instr_op == OP_UPD || instr_op == OP_SQRT));

   p_pass_two_ops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && in_p2) |->
         (instr_op == OP_SQRT || instr_op == OP_DIVR || instr_op == OP_DIVQ));

endmodule

bind qr_sched_seq qrs_seq_checker #(.IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fifo_afull  (fifo_afull),
   .instr_ready (instr_ready),
   .instr_valid (instr_valid),
   .instr_op    (instr_op),
   .instr_k     (instr_k),
   .instr_j     (instr_j),
   .done        (done)
);

// File: tb/sim_qr_sched_seq.sv
`timescale 1ns/1ps
module sim_qr_sched_seq;

   localparam int N     = 4;
   localparam int IW    = 2;
   localparam int TOTAL = 3*N + (3*N*(N-1))/2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          fifo_afull = 1'b0;
   logic          instr_ready = 1'b0;
   logic          instr_valid;
   logic [2:0]    instr_op;
   logic [IW-1:0] instr_k;
   logic [IW-1:0] instr_j;
   logic          done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   qr_sched_seq #(.N_COLS(N), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .fifo_afull(fifo_afull),
      .instr_ready(instr_ready), .instr_valid(instr_valid), .instr_op(instr_op),
      .instr_k(instr_k), .instr_j(instr_j), .done(done)
   );

   int e_op [TOTAL];
   int e_k  [TOTAL];
   int e_j  [TOTAL];

   task automatic build_expected();
      int p = 0;
      for (int k = 0; k < N; k++) begin
         e_op[p] = 1; e_k[p] = k; e_j[p] = k; p++;
         for (int j = k+1; j < N; j++) begin e_op[p] = 1; e_k[p] = k; e_j[p] = j; p++; end
         for (int j = k+1; j < N; j++) begin e_op[p] = 2; e_k[p] = k; e_j[p] = j; p++; end
      end
      for (int k = 0; k < N; k++) begin
         e_op[p] = 3; e_k[p] = k; e_j[p] = k; p++;
         for (int j = k+1; j < N; j++) begin e_op[p] = 4; e_k[p] = k; e_j[p] = j; p++; end
         e_op[p] = 5; e_k[p] = k; e_j[p] = k; p++;
      end
   endtask

   function automatic string req_of(input int op, input int k, input int j);
      if (op == 1 && k == j) return "R2";
      if (op == 1)           return "R3";
      if (op == 2)           return "R4";
      return "R6";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor state
   int idx = 0;
   bit exp_done = 1'b0;
   bit done_seen = 1'b0;
   bit mon_on = 1'b0;
   bit hold_pend = 1'b0;
   int h_op, h_k, h_j;

   always @(negedge clk) begin
      if (mon_on) begin
         if (exp_done || done)
            check(done == exp_done, "R9", "done pulse", int'(done), int'(exp_done));
         if (done) done_seen = 1'b1;
         exp_done = 1'b0;
         if (fifo_afull)
            check(!instr_valid, "R7", "valid under almost-full", int'(instr_valid), 0);
         if (hold_pend) begin
            check(int'(instr_op) == h_op && int'(instr_k) == h_k && int'(instr_j) == h_j,
                  "R8", "held op/k/j packed", int'(instr_op)*256 + int'(instr_k)*16 + int'(instr_j),
                  h_op*256 + h_k*16 + h_j);
         end
         hold_pend = instr_valid && !instr_ready;
         h_op = int'(instr_op); h_k = int'(instr_k); h_j = int'(instr_j);
         if (instr_valid && instr_ready) begin
            if (idx >= TOTAL) begin
               check(1'b0, "R11", "extra instruction count", idx+1, TOTAL);
            end else begin
               check(int'(instr_op) == e_op[idx], req_of(e_op[idx], e_k[idx], e_j[idx]),
                     $sformatf("opcode at %0d (R5 order)", idx), int'(instr_op), e_op[idx]);
               check(int'(instr_k) == e_k[idx], req_of(e_op[idx], e_k[idx], e_j[idx]),
                     $sformatf("k at %0d", idx), int'(instr_k), e_k[idx]);
               check(int'(instr_j) == e_j[idx], req_of(e_op[idx], e_k[idx], e_j[idx]),
                     $sformatf("j at %0d", idx), int'(instr_j), e_j[idx]);
            end
            idx++;
            if (idx == TOTAL) exp_done = 1'b1;
         end
      end
   end

   // mode 0: free flow; 1: random back-pressure; 2: back-pressure plus stray starts
   task automatic run_seq(input int mode);
      idx = 0;
      done_seen = 1'b0;
      @(posedge clk); #1;
      start = 1'b1; instr_ready = 1'b1; fifo_afull = 1'b0;
      @(posedge clk); #1;
      start = 1'b0;
      while (!done_seen) begin
         if (mode == 0) begin
            instr_ready = 1'b1; fifo_afull = 1'b0;
         end else begin
            instr_ready = ($urandom % 4) != 0;
            fifo_afull  = ($urandom % 5) == 0;
            if (mode == 2 && idx < TOTAL-3) start = ($urandom % 3) == 0;
            else start = 1'b0;
         end
         @(posedge clk); #1;
      end
      start = 1'b0; instr_ready = 1'b1; fifo_afull = 1'b0;
      check(idx == TOTAL, "R11", "accepted instruction count", idx, TOTAL);
      repeat (5) begin
         @(negedge clk);
         check(!instr_valid, "R10", "idle after done, no restart", int'(instr_valid), 0);
      end
   endtask

   initial begin
      void'($urandom(32'h00c0ffee));
      build_expected();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      instr_ready = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(!instr_valid, "R1", "valid after reset", int'(instr_valid), 0);
         check(!done, "R1", "done after reset", int'(done), 0);
      end
      mon_on = 1'b1;
      run_seq(0);
      run_seq(1);
      run_seq(1);
      run_seq(2);
      run_seq(2);
      // directed: almost-full held for a long stretch in the middle of a run
      idx = 0; done_seen = 1'b0;
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (7) @(posedge clk);
      #1 fifo_afull = 1'b1;
      repeat (10) @(posedge clk);
      #1 fifo_afull = 1'b0;
      while (!done_seen) @(posedge clk);
      #1;
      check(idx == TOTAL, "R7", "count after long stall", idx, TOTAL);
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule